// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This block turns the three system sleep-control lines into one of three power states (fully on, suspend-to-RAM, soft-off). From that state it drives the enables for three rails: a main-supply switch, a 3.3 V always-on rail and an adjustable memory rail. For each of the two always-on rails it also drives a pair of source selects, one for the main supply and one for the standby supply. When a rail moves from one supply to the other, both selects are held low for a dead time before the new source is enabled.

Digitised undervoltage flags from each rail pass through a persistence counter. A fault that survives the qualification window latches and shuts every output off until standby power is cycled. The standby-good flag is the block's asynchronous power-on reset. A missing 12 V supply or an over-temperature flag forces all outputs off for as long as it lasts, and neither latches. On the first clock after reset the state is loaded from the control code, and a one-cycle softstart request is issued.

Top module: `acpi_seq_top`

## Requirements
- R1: The code {sys_pwr_good, sleep3_n, sleep5_n} = 111 selects the on state (pstate 2'b00), which sets main_en=1, d33_en=1, mem_en=1, d33_src_main=1 and mem_src_main=1, with both standby selects at 0.
- R2: The codes 101, 001 and 011 select suspend (pstate 2'b01) when not in soft-off. Suspend sets main_en=0, d33_en=1, mem_en=1, d33_src_stby=1 and mem_src_stby=1, with both main selects at 0.
- R3: The codes 100, 000 and 010 select soft-off (pstate 2'b10). Soft-off sets main_en=0, mem_en=0 and both memory selects to 0, and keeps d33_en=1 with d33_src_stby=1.
- R4: Code 110 is unused and leaves the current state unchanged.
- R5: Once the block is in soft-off, a suspend code keeps it in soft-off. The only state soft-off can leave for is the on state.
- R6: While stby_ok is low, and until the first rising clock edge after it rises, every output is 0. At that edge the state is loaded from the code, with 001 and 110 both mapping to soft-off and every other code decoded as in R1 to R3.
- R7: softstart_req is high for exactly the one cycle that follows the initial load. It stays low on every later state change.
- R8: A rail fault latches at the QUAL_CYC-th consecutive rising edge at which that rail's undervoltage flag is high while the rail is enabled. A shorter run followed by one low sample restarts the count.
- R9: When fault_latched is set, all enables and selects go to 0 and stay there whatever the code. Only stby_ok going low clears the latch.
- R10: The undervoltage flag of a disabled rail is ignored: uv_mem in soft-off and uv_main outside the on state never cause a latch.
- R11: v12_ok low forces every enable and select to 0 in the same cycle. The outputs return when it goes high again, and nothing latches.
- R12: over_temp high forces every enable and select to 0 in the same cycle. The outputs return when it clears, and nothing latches.
- R13: On a change of source, the two selects of a rail are never high together, and both stay low for at least DEAD_CYC cycles between the old select falling and the new one rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| stby_ok | input | 1 | Standby supply good; low acts as asynchronous reset and clears the fault latch |
| v12_ok | input | 1 | 12 V supply good |
| over_temp | input | 1 | Die over-temperature flag |
| sys_pwr_good | input | 1 | Control code bit 2 |
| sleep3_n | input | 1 | Control code bit 1 |
| sleep5_n | input | 1 | Control code bit 0 |
| uv_main | input | 1 | Main switched rail below 80 % of nominal |
| uv_d33 | input | 1 | 3.3 V always-on rail below 80 % of nominal |
| uv_mem | input | 1 | Memory rail below 80 % of nominal |
| main_en | output | 1 | Main rail switch enable |
| d33_en | output | 1 | 3.3 V always-on rail enable |
| d33_src_main | output | 1 | 3.3 V rail fed from main supply |
| d33_src_stby | output | 1 | 3.3 V rail fed from standby supply |
| mem_en | output | 1 | Memory rail enable |
| mem_src_main | output | 1 | Memory rail fed from main supply |
| mem_src_stby | output | 1 | Memory rail fed from standby supply |
| softstart_req | output | 1 | One-cycle pulse after the initial state load |
| fault_latched | output | 1 | Qualified undervoltage fault is latched |
| pstate | output | 2 | Current state: 00 on, 01 suspend, 10 soft-off |

## Verification
A state change and the expiry of the fault qualifier can land on the same clock edge. The rail mask comes from the registered state, so on that edge the monitor still sees the old state. The bench holds uv_mem high in suspend and moves the code to soft-off in two ways. In the first, the state changes one edge before the window ends; the monitor is masked before expiry and no fault may latch. In the second, the state changes on the very edge the window ends; the fault must latch and every output must drop.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    PS_ON   = 2'b00,
    PS_SUSP = 2'b01,
    PS_OFF  = 2'b10
  } pstate_e;

  // Decode the control code; the unused code keeps the current state.
  function automatic pstate_e code_to_state(input logic [2:0] c, input pstate_e cur);
    pstate_e r;
    case (c)
      3'b111:                 r = PS_ON;
      3'b101, 3'b001, 3'b011: r = PS_SUSP;
      3'b100, 3'b000, 3'b010: r = PS_OFF;
      default:                r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acpi_pstate_fsm.sv
module acpi_pstate_fsm
  import acpi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output pstate_e    pst,
  output logic       init_pend,
  output logic       ss_pulse
);

  pstate_e nxt;

  always_comb begin
    nxt = code_to_state(code, pst);
    // soft-off may only be left towards the on state
    if (pst == PS_OFF && nxt == PS_SUSP) nxt = PS_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst       <= PS_OFF;
      init_pend <= 1'b1;
      ss_pulse  <= 1'b0;
    end else if (init_pend) begin
      init_pend <= 1'b0;
      ss_pulse  <= 1'b1;
      if (code == 3'b001 || code == 3'b110) pst <= PS_OFF;
      else                                  pst <= code_to_state(code, PS_OFF);
    end else begin
      ss_pulse <= 1'b0;
      pst      <= nxt;
    end
  end

  // R5: no direct soft-off to suspend move after the initial load
  p_no_off_to_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pst) == PS_OFF && !$past(init_pend)) |-> (pst != PS_SUSP));

  // R7: softstart pulse lasts one cycle and follows the initial load only
  p_ss_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_pulse |-> ($past(init_pend) && !init_pend));

endmodule

// File: rtl/acpi_uv_qual.sv
module acpi_uv_qual #(
  parameter int QUAL_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  output logic trip
);

  localparam int CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (!mon)          run_q <= '0;
    else if (run_q != LAST) run_q <= run_q + 1'b1;
  end

  assign trip = mon && (run_q == LAST);

  generate
    if (QUAL_CYC > 1) begin : g_chk
      // R8: a trip needs the flag to have been present on the previous edge too
      p_trip_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(mon));
    end
  endgenerate

endmodule

// File: rtl/acpi_src_bbm.sv
module acpi_src_bbm #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic want_main,
  output logic src_main,
  output logic src_stby
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic [CW-1:0] gap_q;
  logic          cur_q, selm_q, sels_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      cur_q  <= 1'b0;
      selm_q <= 1'b0;
      sels_q <= 1'b0;
    end else if (!en) begin
      gap_q  <= '0;
      cur_q  <= want_main;
      selm_q <= 1'b0;
      sels_q <= 1'b0;
    end else if (cur_q != want_main) begin
      gap_q  <= CW'(DEAD_CYC);
      cur_q  <= want_main;
      selm_q <= 1'b0;
      sels_q <= 1'b0;
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - 1'b1;
      selm_q <= 1'b0;
      sels_q <= 1'b0;
    end else begin
      selm_q <= cur_q;
      sels_q <= !cur_q;
    end
  end

  assign src_main = selm_q & en;
  assign src_stby = sels_q & en;

  // R13: a select only rises if the other one was low on the previous edge
  p_main_after_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selm_q) |-> !$past(sels_q));
  p_stby_after_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sels_q) |-> !$past(selm_q));

endmodule

// File: rtl/acpi_seq_top.sv
module acpi_seq_top
  import acpi_seq_pkg::*;
#(
  parameter int QUAL_CYC = 15000,
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       stby_ok,
  input  logic       v12_ok,
  input  logic       over_temp,
  input  logic       sys_pwr_good,
  input  logic       sleep3_n,
  input  logic       sleep5_n,
  input  logic       uv_main,
  input  logic       uv_d33,
  input  logic       uv_mem,
  output logic       main_en,
  output logic       d33_en,
  output logic       d33_src_main,
  output logic       d33_src_stby,
  output logic       mem_en,
  output logic       mem_src_main,
  output logic       mem_src_stby,
  output logic       softstart_req,
  output logic       fault_latched,
  output logic [1:0] pstate
);

  localparam int NRAIL = 3;

  pstate_e          pst;
  logic             init_pend;
  logic             off_all;
  logic             want_main;
  logic [NRAIL-1:0] mon_v, trip_v;
  logic             fault_q;

  acpi_pstate_fsm u_fsm (
    .clk       (clk),
    .rst_n     (stby_ok),
    .code      ({sys_pwr_good, sleep3_n, sleep5_n}),
    .pst       (pst),
    .init_pend (init_pend),
    .ss_pulse  (softstart_req)
  );

  assign off_all   = init_pend | !v12_ok | over_temp | fault_q;
  assign want_main = (pst == PS_ON);
  assign main_en   = !off_all && (pst == PS_ON);
  assign d33_en    = !off_all;
  assign mem_en    = !off_all && (pst != PS_OFF);

  acpi_src_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm_d33 (
    .clk       (clk),
    .rst_n     (stby_ok),
    .en        (d33_en),
    .want_main (want_main),
    .src_main  (d33_src_main),
    .src_stby  (d33_src_stby)
  );

  acpi_src_bbm #(.DEAD_CYC(DEAD_CYC)) u_bbm_mem (
    .clk       (clk),
    .rst_n     (stby_ok),
    .en        (mem_en),
    .want_main (want_main),
    .src_main  (mem_src_main),
    .src_stby  (mem_src_stby)
  );

  // each monitor is masked while its own rail is disabled
  assign mon_v = {uv_mem & mem_en, uv_d33 & d33_en, uv_main & main_en};

  for (genvar g = 0; g < NRAIL; g++) begin : g_qual
    acpi_uv_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk   (clk),
      .rst_n (stby_ok),
      .mon   (mon_v[g]),
      .trip  (trip_v[g])
    );
  end

  always_ff @(posedge clk or negedge stby_ok) begin
    if (!stby_ok)     fault_q <= 1'b0;
    else if (|trip_v) fault_q <= 1'b1;
  end

  assign fault_latched = fault_q;
  assign pstate        = pst;

  // R9: the latch holds until standby power is removed
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!stby_ok)
    $past(fault_q) |-> fault_q);
  // R9: a latched fault leaves every rail and select off
  p_fault_all_off_r9: assert property (@(posedge clk) disable iff (!stby_ok)
    fault_q |-> !(main_en || d33_src_main || d33_src_stby || mem_src_main || mem_src_stby));
  // R12: over-temperature leaves no select active
  p_thermal_off_r12: assert property (@(posedge clk) disable iff (!stby_ok)
    over_temp |-> !(d33_src_main || d33_src_stby || mem_src_main || mem_src_stby));
  // R3: the memory rail has no active source in soft-off
  p_mem_off_r3: assert property (@(posedge clk) disable iff (!stby_ok)
    (pst == PS_OFF) |-> !(mem_src_main || mem_src_stby));

endmodule

// File: tb/sim_acpi_seq_top.sv
module sim_acpi_seq_top;

  localparam int QUAL = 40;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic stby_ok = 1'b0, v12_ok = 1'b1, over_temp = 1'b0;
  logic [2:0] code = 3'b111;
  logic uv_main = 1'b0, uv_d33 = 1'b0, uv_mem = 1'b0;
  logic main_en, d33_en, d33_src_main, d33_src_stby, mem_en, mem_src_main, mem_src_stby;
  logic softstart_req, fault_latched;
  logic [1:0] pstate;

  acpi_seq_top #(.QUAL_CYC(QUAL), .DEAD_CYC(DEAD)) u0 (
    .clk(clk), .stby_ok(stby_ok), .v12_ok(v12_ok), .over_temp(over_temp),
    .sys_pwr_good(code[2]), .sleep3_n(code[1]), .sleep5_n(code[0]),
    .uv_main(uv_main), .uv_d33(uv_d33), .uv_mem(uv_mem),
    .main_en(main_en), .d33_en(d33_en), .d33_src_main(d33_src_main),
    .d33_src_stby(d33_src_stby), .mem_en(mem_en), .mem_src_main(mem_src_main),
    .mem_src_stby(mem_src_stby), .softstart_req(softstart_req),
    .fault_latched(fault_latched), .pstate(pstate)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [2:0] code;
    logic [1:0] st;
    logic [6:0] outs;
    logic [3:0] req;
  } vec_t;

  // outs = {main_en, d33_en, d33_src_main, d33_src_stby, mem_en, mem_src_main, mem_src_stby}
  localparam vec_t VECS [15] = '{
    '{3'b111, 2'b00, 7'b1110110, 4'd1},
    '{3'b101, 2'b01, 7'b0101101, 4'd2},
    '{3'b110, 2'b01, 7'b0101101, 4'd4},
    '{3'b011, 2'b01, 7'b0101101, 4'd2},
    '{3'b100, 2'b10, 7'b0101000, 4'd3},
    '{3'b001, 2'b10, 7'b0101000, 4'd5},
    '{3'b011, 2'b10, 7'b0101000, 4'd5},
    '{3'b110, 2'b10, 7'b0101000, 4'd4},
    '{3'b000, 2'b10, 7'b0101000, 4'd3},
    '{3'b111, 2'b00, 7'b1110110, 4'd1},
    '{3'b001, 2'b01, 7'b0101101, 4'd2},
    '{3'b010, 2'b10, 7'b0101000, 4'd3},
    '{3'b101, 2'b10, 7'b0101000, 4'd5},
    '{3'b111, 2'b00, 7'b1110110, 4'd1},
    '{3'b110, 2'b00, 7'b1110110, 4'd4}
  };

  function automatic string tag(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [6:0] outs();
    return {main_en, d33_en, d33_src_main, d33_src_stby, mem_en, mem_src_main, mem_src_stby};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic por(input logic [2:0] c);
    @(negedge clk);
    stby_ok = 1'b0; code = c;
    uv_main = 0; uv_d33 = 0; uv_mem = 0; v12_ok = 1; over_temp = 0;
    repeat (3) @(negedge clk);
    stby_ok = 1'b1;
    #1;
  endtask

  task automatic settle();
    repeat (DEAD + 8) @(negedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int ss_seen;
    int gap, both;
    // R6: reset state
    @(negedge clk);
    chk(outs() == 7'd0 && !softstart_req && !fault_latched, "R6", "outputs in reset", outs(), 0);
    stby_ok = 1'b1; #1;
    chk(outs() == 7'd0, "R6", "outputs before first edge", outs(), 0);
    @(negedge clk);
    chk(pstate == 2'b00, "R6", "initial state for 111", pstate, 0);
    chk(softstart_req == 1'b1, "R7", "softstart after initial load", softstart_req, 1);
    @(negedge clk);
    chk(softstart_req == 1'b0, "R7", "softstart one cycle", softstart_req, 0);
    settle();

    // table walk: R1..R5
    ss_seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      code = VECS[i].code;
      for (int k = 0; k < DEAD + 8; k++) begin
        @(negedge clk);
        if (softstart_req) ss_seen++;
      end
      chk(pstate == VECS[i].st, tag(VECS[i].req), $sformatf("state vec %0d", i), pstate, VECS[i].st);
      chk(outs() == VECS[i].outs, tag(VECS[i].req), $sformatf("outputs vec %0d", i), outs(), VECS[i].outs);
    end
    chk(ss_seen == 0, "R7", "no softstart on transitions", ss_seen, 0);

    // R6: initial decode of 001 and 110 both give soft-off
    por(3'b001);
    @(negedge clk);
    chk(pstate == 2'b10, "R6", "initial 001", pstate, 2);
    por(3'b110);
    @(negedge clk);
    chk(pstate == 2'b10, "R6", "initial 110", pstate, 2);
    por(3'b101);
    @(negedge clk);
    chk(pstate == 2'b01, "R6", "initial 101", pstate, 1);
    settle();

    // R13: suspend -> on, watch the 3.3 V rail selects every cycle
    code = 3'b111; gap = 0; both = 0;
    for (int k = 0; k < DEAD + 10; k++) begin
      @(negedge clk);
      if (d33_src_main && d33_src_stby) both++;
      if (!d33_src_main && !d33_src_stby) gap++;
    end
    chk(both == 0, "R13", "selects never both high", both, 0);
    chk(gap >= DEAD, "R13", "dead cycles", gap, DEAD);
    chk(d33_src_main && mem_src_main, "R13", "main source after gap", outs(), 7'b1110110);

    // R11: 12 V loss, no latch
    v12_ok = 0; #1;
    chk(outs() == 7'd0, "R11", "12V low forces off", outs(), 0);
    @(negedge clk); v12_ok = 1; settle();
    chk(outs() == 7'b1110110 && !fault_latched, "R11", "return after 12V", outs(), 7'b1110110);

    // R12: over-temperature, no latch
    over_temp = 1; #1;
    chk(outs() == 7'd0, "R12", "over-temp forces off", outs(), 0);
    @(negedge clk); over_temp = 0; settle();
    chk(outs() == 7'b1110110 && !fault_latched, "R12", "return after over-temp", outs(), 7'b1110110);

    // R8: short run, reset by a low sample, then full run
    uv_d33 = 1;
    repeat (QUAL - 1) @(negedge clk);
    uv_d33 = 0;
    @(negedge clk);
    chk(!fault_latched, "R8", "short run no latch", fault_latched, 0);
    uv_d33 = 1;
    repeat (QUAL - 1) @(negedge clk);
    chk(!fault_latched, "R8", "one edge before window", fault_latched, 0);
    @(negedge clk);
    chk(fault_latched, "R8", "latch at window end", fault_latched, 1);
    uv_d33 = 0;
    // R9: held off whatever the code
    chk(outs() == 7'd0, "R9", "all off after fault", outs(), 0);
    code = 3'b101; settle();
    chk(outs() == 7'd0 && fault_latched, "R9", "fault held over code change", outs(), 0);
    por(3'b111);
    @(negedge clk);
    chk(!fault_latched, "R9", "cleared by standby cycle", fault_latched, 0);
    settle();

    // R10: uv_mem in soft-off and uv_main in suspend are ignored
    code = 3'b100; settle();
    uv_mem = 1; repeat (2 * QUAL) @(negedge clk);
    chk(!fault_latched && d33_en, "R10", "mem flag masked in soft-off", fault_latched, 0);
    uv_mem = 0;
    code = 3'b111; settle(); code = 3'b101; settle();
    uv_main = 1; repeat (2 * QUAL) @(negedge clk);
    chk(!fault_latched && outs() == 7'b0101101, "R10", "main flag masked in suspend", outs(), 7'b0101101);
    uv_main = 0;

    // concurrent: state change one edge before window end -> masked, no latch
    por(3'b101);
    settle();
    uv_mem = 1;
    repeat (QUAL - 2) @(negedge clk);
    code = 3'b100;
    repeat (3) @(negedge clk);
    chk(!fault_latched && pstate == 2'b10, "R10", "soft-off before expiry masks", fault_latched, 0);
    uv_mem = 0;

    // concurrent: state change on the same edge as expiry -> latch wins
    por(3'b101);
    settle();
    uv_mem = 1;
    repeat (QUAL - 1) @(negedge clk);
    code = 3'b100;
    @(negedge clk);
    chk(fault_latched, "R8", "expiry on state-change edge latches", fault_latched, 1);
    chk(outs() == 7'd0, "R9", "all off after same-edge trip", outs(), 0);
    uv_mem = 0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule